// File: doc/BRIEF.md
# Block-Write Configuration Slave for a Clock Generator

This block is a write-only two-wire serial slave that loads a small bank of byte-wide configuration registers for a clock generator. A master opens a transaction with START and sends the fixed write address byte 0xD2. It then sends a command-code byte and a byte-count byte, followed by data bytes. The slave acknowledges the command and count bytes but ignores their values. Data always streams into the bank starting at register 0.

The register bank appears as one flat parallel output. Defaults load only on the power-on reset `rst_ni`. The active-low power-down input leaves the stored contents untouched. SDA and SCL are modelled in open-drain form: each line has an input, an output value and an output enable. The slave never drives SCL, and it drives SDA low only to acknowledge. Both line inputs pass through two-flop synchronizers on the system clock. START and STOP are recognised as SDA edges while SCL is high.

Top module: `smbus_cfg_slave`

## Requirements
- R1: An address byte of 0xD2 (7-bit address with the write bit 0) is acknowledged.
- R2: An address byte other than 0xD2, including 0xD3 (read bit set), is not acknowledged. The slave then acknowledges no byte and writes no register until the next START.
- R3: The two bytes after the address (command code, then byte count) are both acknowledged. Their values change neither which register is written nor how many are written; the first data byte always goes to register 0.
- R4: Data bytes are written in order to registers 0, 1 and 2. `regs_o[7:0]` is register 0, `regs_o[15:8]` is register 1 and `regs_o[23:16]` is register 2. Every data byte is acknowledged, and bytes after the third are discarded.
- R5: On power-on reset (`rst_ni` low) the registers take their defaults: register 0 = 0x0C, register 1 = 0xCF, register 2 = 0x7F.
- R6: Driving `pwrdn_ni` low leaves every register value unchanged.
- R7: A repeated START at any point makes the slave expect a new address byte. The next data sequence restarts at register 0.
- R8: The acknowledge drives SDA low (`sda_oe_o` = 1, `sda_o` = 0) from the eighth SCL falling edge, through the ninth SCL high period, until the ninth SCL falling edge. SCL is never driven (`scl_oe_o` = 0).
- R9: All bits of a data byte are stored as written, including bits that control no function (register 1 bits 5:4, register 2 bit 7).
- R10: After a STOP, bytes clocked without a new START get no acknowledge and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the bus |
| rst_ni | input | 1 | Active-low asynchronous power-on reset; loads defaults |
| pwrdn_ni | input | 1 | Active-low power-down; does not touch registers |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_oe_o | output | 1 | SCL output enable (always 0) |
| sda_o | output | 1 | SDA output value (0) |
| sda_oe_o | output | 1 | SDA output enable; high while acknowledging |
| regs_o | output | NUM_REGS*8 | Register bank, register 0 in the low byte |

## Verification
The assertions check on every cycle:
- The acknowledge turns on only while synchronized SCL is low, and it drops at the SCL falling edge that ends the ninth clock.
- Every register write comes with an acknowledge and targets an index inside the bank.
- The bank changes only on a write pulse, so holding `pwrdn_ni` low cannot alter it.

Only the bench's scenarios can show the following:
- Acceptance of 0xD2 and rejection of other addresses.
- That command and count values are ignored.
- That extra bytes are discarded.
- That a repeated START restarts the sequence at register 0.
- That bytes after a STOP are ignored.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  // idle bus is high, so synchronizers reset to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
endmodule

// File: rtl/smbus_byte_engine.sv
module smbus_byte_engine
  import smbus_cfg_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE = 8'hD2,
  parameter int         NUM_REGS  = 3,
  localparam int        IDX_W     = $clog2(NUM_REGS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  output logic              ack_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  phase_e            phase_q;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      idx_q     <= '0;
      ack_q     <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (stop_i) begin
        phase_q   <= PH_IDLE;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise_i && bit_cnt_q < 4'd8) begin
          shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
          if (ack_q) begin
            // end of ninth clock: release SDA, next byte
            ack_q     <= 1'b0;
            bit_cnt_q <= '0;
          end else begin
            unique case (phase_q)
              PH_ADDR: begin
                if (shreg_q == ADDR_BYTE) begin
                  ack_q   <= 1'b1;
                  phase_q <= PH_CMD;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end
              PH_CMD: begin
                ack_q   <= 1'b1;
                phase_q <= PH_CNT;
              end
              PH_CNT: begin
                ack_q   <= 1'b1;
                phase_q <= PH_DATA;
                idx_q   <= '0;
              end
              PH_DATA: begin
                ack_q <= 1'b1;
                if (idx_q < IDX_W'(NUM_REGS)) begin
                  wr_en_o   <= 1'b1;
                  wr_idx_o  <= idx_q;
                  wr_data_o <= shreg_q;
                  idx_q     <= idx_q + 1'b1;
                end
              end
              default: phase_q <= PH_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign ack_o = ack_q;

  AST_ACK_SET_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> !scl_lvl_i); // R8
  AST_ACK_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_q && scl_fall_i) |=> !ack_q); // R8
  AST_WR_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_idx_o < IDX_W'(NUM_REGS))); // R4
  AST_WR_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> ack_q); // R4
endmodule

// File: rtl/smbus_reg_bank.sv
module smbus_reg_bank
  import smbus_cfg_pkg::*;
#(
  parameter int                         NUM_REGS = 3,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS = 24'h7FCF0C,
  localparam int                        IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  output logic [NUM_REGS*BYTE_W-1:0]   regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[i*BYTE_W +: BYTE_W] <= DEFAULTS[i*BYTE_W +: BYTE_W];
      else if (wr_en_i && wr_idx_i == IDX_W'(i))
        regs_o[i*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end

  AST_REG_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o)); // R4
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter logic [7:0]                 ADDR_BYTE = 8'hD2,
  parameter int                         NUM_REGS  = 3,
  parameter logic [NUM_REGS*BYTE_W-1:0] DEFAULTS  = 24'h7FCF0C,
  parameter int                         SYNC_STG  = 2,
  localparam int                        IDX_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pwrdn_ni,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       scl_o,
  output logic                       scl_oe_o,
  output logic                       sda_o,
  output logic                       sda_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic scl_s, sda_s, start, stop, scl_rise, scl_fall, ack;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;

  smbus_line_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .start_o    (start),
    .stop_o     (stop),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  smbus_byte_engine #(.ADDR_BYTE(ADDR_BYTE), .NUM_REGS(NUM_REGS)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (scl_s),
    .sda_lvl_i  (sda_s),
    .start_i    (start),
    .stop_i     (stop),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .ack_o      (ack),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data)
  );

  smbus_reg_bank #(.NUM_REGS(NUM_REGS), .DEFAULTS(DEFAULTS)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_data),
    .regs_o    (regs_o)
  );

  // open-drain: SCL never driven, SDA only pulled low for acknowledge
  assign scl_o    = 1'b0;
  assign scl_oe_o = 1'b0;
  assign sda_o    = 1'b0;
  assign sda_oe_o = ack;

  AST_PWRDN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwrdn_ni && !wr_en) |=> $stable(regs_o)); // R6
endmodule

// File: tb/smbus_cfg_slave_bench.sv
`timescale 1ns/1ps
module smbus_cfg_slave_bench;
  localparam int Q = 16;

  logic clk = 1'b0, rst_n = 1'b0, pwrdn_n = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_o, scl_oe, sda_o, sda_oe;
  logic [23:0] regs;
  wire sda_line = sda_m & ~(sda_oe & ~sda_o);
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  smbus_cfg_slave u_smbus_cfg_slave (
    .clk_i(clk), .rst_ni(rst_n), .pwrdn_ni(pwrdn_n),
    .scl_i(scl_m), .sda_i(sda_line),
    .scl_o(scl_o), .scl_oe_o(scl_oe), .sda_o(sda_o), .sda_oe_o(sda_oe),
    .regs_o(regs)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  // sends a byte with SCL low on entry; returns whether it was acknowledged
  task automatic send_byte(input logic [7:0] b, output bit acked, output bit timing_ok);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1;
    wq();
    timing_ok = 1'b1;
    acked = sda_oe;
    scl_m = 1'b1; wq(Q/2);
    if ((sda_line == 1'b0) != acked) timing_ok = 1'b0;
    wq(Q/2);
    scl_m = 1'b0; wq();
    if (sda_oe) timing_ok = 1'b0;
  endtask

  task automatic expect_ack(input logic [7:0] b, input bit exp, input string tag);
    bit a, t;
    send_byte(b, a, t);
    chk(a == exp, tag, {31'd0, a}, {31'd0, exp});
    chk(t, {tag, " R8 ack timing"}, {31'd0, t}, 32'd1);
  endtask

  task automatic t_reset();
    chk(regs == 24'h7FCF0C, "R5 reset defaults", regs, 24'h7FCF0C);
    chk(sda_oe == 1'b0, "R8 sda idle", sda_oe, 0);
    chk(scl_oe == 1'b0, "R8 scl never driven", scl_oe, 0);
  endtask

  task automatic t_full_write();
    bus_start();
    expect_ack(8'hD2, 1, "R1 addr D2");
    expect_ack(8'h55, 1, "R3 cmd");
    expect_ack(8'h03, 1, "R3 count");
    expect_ack(8'hA1, 1, "R4 data0");
    expect_ack(8'hB2, 1, "R4 data1");
    expect_ack(8'hC3, 1, "R4 data2");
    expect_ack(8'h99, 1, "R4 extra byte acked");
    bus_stop();
    chk(regs == 24'hC3B2A1, "R4 R9 bank after write", regs, 24'hC3B2A1);
    chk(scl_oe == 1'b0, "R8 scl not driven", scl_oe, 0);
  endtask

  task automatic t_cmd_ignored();
    bus_start();
    expect_ack(8'hD2, 1, "R1 addr");
    expect_ack(8'h02, 1, "R3 cmd 02");
    expect_ack(8'h01, 1, "R3 count 01");
    expect_ack(8'h11, 1, "R3 data0");
    expect_ack(8'h22, 1, "R3 data1");
    bus_stop();
    chk(regs == 24'hC32211, "R3 command and count ignored", regs, 24'hC32211);
  endtask

  task automatic t_bad_addr();
    bus_start();
    expect_ack(8'hD4, 0, "R2 wrong addr");
    expect_ack(8'h00, 0, "R2 ignored after nack");
    expect_ack(8'h5A, 0, "R2 ignored after nack 2");
    bus_stop();
    bus_start();
    expect_ack(8'hD3, 0, "R2 read bit");
    expect_ack(8'h00, 0, "R2 ignored after read");
    bus_stop();
    chk(regs == 24'hC32211, "R2 bank unchanged", regs, 24'hC32211);
  endtask

  task automatic t_after_stop();
    scl_m = 1'b0; wq();
    expect_ack(8'hD2, 0, "R10 addr without start");
    expect_ack(8'h00, 0, "R10 byte without start");
    expect_ack(8'h77, 0, "R10 data without start");
    bus_stop();
    chk(regs == 24'hC32211, "R10 bank unchanged", regs, 24'hC32211);
  endtask

  task automatic t_rstart();
    bus_start();
    expect_ack(8'hD2, 1, "R7 addr");
    expect_ack(8'h00, 1, "R7 cmd");
    expect_ack(8'h00, 1, "R7 count");
    expect_ack(8'h44, 1, "R7 data0");
    bus_start();
    expect_ack(8'hD2, 1, "R7 addr after rstart");
    expect_ack(8'hF0, 1, "R7 cmd after rstart");
    expect_ack(8'h09, 1, "R7 count after rstart");
    expect_ack(8'h66, 1, "R7 data restarts at 0");
    bus_stop();
    chk(regs == 24'hC32266, "R7 restart at register 0", regs, 24'hC32266);
    bus_start();
    expect_ack(8'hD2, 1, "R7 addr 2");
    bus_start();
    expect_ack(8'h00, 0, "R7 byte after rstart is address");
    bus_stop();
    chk(regs == 24'hC32266, "R7 bank after bad rstart", regs, 24'hC32266);
  endtask

  task automatic t_pwrdn();
    pwrdn_n = 1'b0;
    wq(100);
    chk(regs == 24'hC32266, "R6 power-down keeps bank", regs, 24'hC32266);
    pwrdn_n = 1'b1;
    wq(10);
    chk(regs == 24'hC32266, "R6 power-down release keeps bank", regs, 24'hC32266);
    rst_n = 1'b0; wq(4);
    chk(regs == 24'h7FCF0C, "R5 defaults on power-on reset", regs, 24'h7FCF0C);
    rst_n = 1'b1; wq(4);
  endtask

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_full_write();
    t_cmd_ignored();
    t_bad_addr();
    t_after_stop();
    t_rstart();
    t_pwrdn();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule